// File: doc/BRIEF.md
# Serial GF(2) Polynomial Multiplier / Divider

This block takes a binary sequence one coefficient per accepted beat, lowest power of X first, and treats it as a polynomial over GF(2). A frame begins with a start marker and ends with an end marker. A mode input is sampled on the start beat.

In multiply mode the block sends out the coefficients of the product of the frame and a fixed polynomial. It forms them with a tapped delay line over the recent input bits. After the last input it runs extra zero steps until the whole product has been emitted. In divide mode a feedback shift register produces the power-series quotient of the frame by a fixed polynomial, one bit per input bit. When the frame ends, the block reports whether the divisor divides the frame exactly.

Used as a pair, one instance in multiply mode encodes data into a non-systematic code word. A second instance in divide mode recovers the data and rejects corrupted words. Both polynomials are parameters written as coefficient vectors, where bit j is the coefficient of X^j. Both default to 1 + X^2 + X^15 + X^16, which has degree DEG = 16.

Top module: `gf2_serial_muldiv`

## Requirements
- R1: While reset is asserted, and after its release until the first accepted beat, out_valid, chk_done and rej_flag are 0.
- R2: In multiply mode (mode_div = 0 on the start beat), the k-th output bit equals the XOR over j of MUL_POLY[j]·a[k-j]. Here a[i] is the i-th accepted bit of the frame (first bit = X^0), and a[i] = 0 outside the frame. Each output appears with out_valid one cycle after the beat that produced it.
- R3: In multiply mode, the cycle after the end beat starts DEG consecutive zero-input steps. Each step emits one output, so a frame of L bits yields exactly L + DEG output bits.
- R4: During these DEG flush cycles, in_valid, in_bit, in_sof, in_eof and mode_div are ignored. The emitted product is unchanged and no extra outputs appear.
- R5: In divide mode (mode_div = 1 on the start beat), each accepted bit r[n] yields one output q[n] one cycle later, where q[n] = r[n] XOR (XOR over j≥1 of DIV_POLY[j]·q[n-j]). A frame of L bits yields exactly L outputs. DIV_POLY[0] must be 1.
- R6: In divide mode, chk_done is 1 for exactly the cycle after the end beat. In that cycle rej_flag is 1 exactly when the frame polynomial leaves a nonzero remainder modulo DIV_POLY. A frame equal to A·DIV_POLY outputs the bits of A followed by DEG zeros, with rej_flag 0.
- R7: rej_flag keeps its value until the next start beat. It reads 0 from the cycle after that beat, unless the start beat is also an end beat.
- R8: The mode is taken from mode_div only on the start beat. Changes of mode_div later in the frame have no effect.
- R9: Cycles with in_valid = 0 neither advance the computation nor produce an output.
- R10: In multiply mode, chk_done stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_div | input | 1 | 0 = multiply, 1 = divide; sampled on the start beat |
| in_valid | input | 1 | Input coefficient present this cycle |
| in_bit | input | 1 | Input coefficient |
| in_sof | input | 1 | Marks the first coefficient of a frame (X^0) |
| in_eof | input | 1 | Marks the last coefficient of a frame |
| out_valid | output | 1 | Output coefficient present this cycle |
| out_bit | output | 1 | Product or quotient coefficient |
| chk_done | output | 1 | One-cycle pulse: divide-mode frame check complete |
| rej_flag | output | 1 | Nonzero remainder seen in the last checked frame |

## Verification
The bench covers several corner cases:
- **Frame boundaries.** It sends one-bit frames where start and end coincide, and frames shorter than the divisor degree. A divider that tested only part of the feedback register, or that forgot the frame's own first bit, would give the wrong accept/reject answer on these.
- **Flush window.** It drives live traffic with start markers during the flush window. A multiplier that accepted it would corrupt the product tail or emit too many bits.
- **Gaps and mode changes.** It inserts idle cycles inside frames and toggles the mode mid-frame. A design that advanced on idle cycles or re-read the mode would produce a scrambled stream.
- **Check result.** Clean encoded words must come back as the original data followed by zeros, and single-bit corruptions must raise the reject flag. That flag is then watched until the next start clears it.

// File: rtl/gf2_pkg.sv
package gf2_pkg;

  typedef enum logic {
    MODE_MUL = 1'b0,
    MODE_DIV = 1'b1
  } op_mode_e;

  // 1 + X^2 + X^15 + X^16, bit j = coefficient of X^j
  localparam logic [16:0] POLY_DEG16 = 17'h18005;

endpackage

// File: rtl/gf2_frame_ctl.sv
module gf2_frame_ctl
  import gf2_pkg::*;
#(
  parameter int DEG = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  input  logic     in_sof,
  input  logic     in_eof,
  input  op_mode_e mode_req,
  output logic     beat,
  output logic     start_beat,
  output logic     end_beat,
  output logic     flush_step,
  output op_mode_e cur_mode
);

  localparam int CW = $clog2(DEG + 1);

  logic [CW-1:0] flush_cnt_q, flush_cnt_d;
  op_mode_e      mode_q;
  logic          mode_en;

  always_comb begin
    flush_step  = (flush_cnt_q != '0);
    beat        = in_valid && !flush_step;
    start_beat  = beat && in_sof;
    end_beat    = beat && in_eof;
    cur_mode    = start_beat ? mode_req : mode_q;
    mode_en     = start_beat;
    flush_cnt_d = flush_cnt_q;
    if (flush_step) begin
      flush_cnt_d = flush_cnt_q - 1'b1;
    end else if (end_beat && (cur_mode == MODE_MUL)) begin
      flush_cnt_d = CW'(DEG);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_cnt_q <= '0;
    end else begin
      flush_cnt_q <= flush_cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_MUL;
    end else if (mode_en) begin
      mode_q <= mode_req;
    end
  end

  // R3: the flush window counts down one step per cycle
  assert_flush_countdown_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    flush_step |=> (flush_cnt_q == CW'($past(flush_cnt_q) - 1'b1)));

  // R3: a multiply frame end opens a full flush window
  assert_flush_open_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (end_beat && (cur_mode == MODE_MUL)) |=> (flush_cnt_q == CW'(DEG)));

  // R8: the frame mode moves only on a start beat
  assert_mode_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    !start_beat |=> $stable(mode_q));

endmodule

// File: rtl/gf2_tap_mult.sv
module gf2_tap_mult #(
  parameter int             DEG  = 16,
  parameter logic [DEG:0]   POLY = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clear,
  input  logic din,
  output logic prod
);

  logic [DEG-1:0] hist_q, hist_d, hist_eff;
  logic [DEG:0]   terms;

  assign hist_eff = clear ? '0 : hist_q;

  generate
    for (genvar j = 0; j <= DEG; j++) begin : g_tap
      if (j == 0) begin : g_cur
        assign terms[j] = POLY[j] & din;
      end else begin : g_old
        assign terms[j] = POLY[j] & hist_eff[j-1];
      end
    end
  endgenerate

  assign prod = ^terms;

  always_comb begin
    hist_d = hist_q;
    if (step) begin
      hist_d = DEG'({hist_eff, din});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

endmodule

// File: rtl/gf2_fb_div.sv
module gf2_fb_div #(
  parameter int           DEG  = 16,
  parameter logic [DEG:0] POLY = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clear,
  input  logic din,
  output logic q,
  output logic rem_nz
);

  logic [DEG-1:0] qh_q, qh_d, qh_eff;
  logic [DEG:1]   fb;

  assign qh_eff = clear ? '0 : qh_q;

  generate
    for (genvar j = 1; j <= DEG; j++) begin : g_fb
      assign fb[j] = POLY[j] & qh_eff[j-1];
    end
  endgenerate

  assign q = din ^ (^fb);

  always_comb begin
    qh_d = qh_q;
    if (step) begin
      qh_d = DEG'({qh_eff, q});
    end
  end

  // the last DEG quotient bits are zero exactly when the divisor divides the frame
  assign rem_nz = |qh_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qh_q <= '0;
    end else begin
      qh_q <= qh_d;
    end
  end

endmodule

// File: rtl/gf2_serial_muldiv.sv
module gf2_serial_muldiv
  import gf2_pkg::*;
#(
  parameter int           DEG      = 16,
  parameter logic [DEG:0] MUL_POLY = POLY_DEG16,
  parameter logic [DEG:0] DIV_POLY = POLY_DEG16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_div,
  input  logic in_valid,
  input  logic in_bit,
  input  logic in_sof,
  input  logic in_eof,
  output logic out_valid,
  output logic out_bit,
  output logic chk_done,
  output logic rej_flag
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  logic     beat, start_beat, end_beat, flush_step;
  op_mode_e cur_mode;

  gf2_frame_ctl #(.DEG(DEG)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .mode_req   (op_mode_e'(mode_div)),
    .beat       (beat),
    .start_beat (start_beat),
    .end_beat   (end_beat),
    .flush_step (flush_step),
    .cur_mode   (cur_mode)
  );

  logic mul_step, mul_din, mul_prod;
  logic div_step, div_q, div_rem_nz;

  always_comb begin
    mul_step = (beat && (cur_mode == MODE_MUL)) || flush_step;
    mul_din  = flush_step ? 1'b0 : in_bit;
    div_step = beat && (cur_mode == MODE_DIV);
  end

  gf2_tap_mult #(.DEG(DEG), .POLY(MUL_POLY)) u_mul (
    .clk   (clk),
    .rst_n (rst_int_n),
    .step  (mul_step),
    .clear (start_beat),
    .din   (mul_din),
    .prod  (mul_prod)
  );

  gf2_fb_div #(.DEG(DEG), .POLY(DIV_POLY)) u_div (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .step   (div_step),
    .clear  (start_beat),
    .din    (in_bit),
    .q      (div_q),
    .rem_nz (div_rem_nz)
  );

  logic valid_q, valid_d, bit_q, bit_d, chk_q, chk_d, rej_q, rej_d;

  always_comb begin
    valid_d = beat || flush_step;
    bit_d   = (cur_mode == MODE_DIV) ? div_q : mul_prod;
    chk_d   = end_beat && (cur_mode == MODE_DIV);
    rej_d   = rej_q;
    if (start_beat) begin
      rej_d = 1'b0;
    end
    if (chk_d) begin
      rej_d = div_rem_nz;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
      chk_q   <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      chk_q   <= chk_d;
      rej_q   <= rej_d;
      if (valid_d) begin
        bit_q <= bit_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_bit   = bit_q;
  assign chk_done  = chk_q;
  assign rej_flag  = rej_q;

  // R9: every output traces back to an accepted beat or a flush step
  assert_out_has_source_R9 : assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> $past(beat || flush_step));

  // R6: the check pulse follows an end beat at the port
  assert_chk_after_end_R6 : assert property (@(posedge clk) disable iff (!rst_int_n)
    chk_done |-> $past(in_valid && in_eof));

  // R10: no check pulse for a multiply frame
  assert_no_chk_mul_R10 : assert property (@(posedge clk) disable iff (!rst_int_n)
    chk_done |-> $past(cur_mode == MODE_DIV));

  // R7: the verdict holds between checks and start beats
  assert_rej_hold_R7 : assert property (@(posedge clk) disable iff (!rst_int_n)
    (!chk_done && !$past(start_beat)) |-> $stable(rej_flag));

  // R7: a start beat that is not also an end beat clears the verdict
  assert_rej_clear_R7 : assert property (@(posedge clk) disable iff (!rst_int_n)
    (start_beat && !end_beat) |=> !rej_flag);

endmodule

// File: tb/gf2_serial_muldiv_test.sv
module gf2_serial_muldiv_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEG = 16;
  localparam logic [DEG:0] POLY = 17'h18005;

  typedef bit bitq_t[$];

  logic clk = 1'b0;
  logic rst_n, mode_div, in_valid, in_bit, in_sof, in_eof;
  logic out_valid, out_bit, chk_done, rej_flag;

  int n_chk = 0;
  int n_err = 0;
  int n_out = 0;
  bit mon_en = 1'b0;
  bit exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  gf2_serial_muldiv #(.DEG(DEG), .MUL_POLY(POLY), .DIV_POLY(POLY)) uut (
    .clk(clk), .rst_n(rst_n), .mode_div(mode_div), .in_valid(in_valid),
    .in_bit(in_bit), .in_sof(in_sof), .in_eof(in_eof), .out_valid(out_valid),
    .out_bit(out_bit), .chk_done(chk_done), .rej_flag(rej_flag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // stream monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (mon_en && out_valid) begin
      n_out++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R5 unexpected output", 1, 0);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_bit == e, t, out_bit, e);
      end
    end
  end

  function automatic bitq_t polymul(input bitq_t a);
    bitq_t c;
    for (int k = 0; k < a.size() + DEG; k++) begin
      bit s = 1'b0;
      for (int j = 0; j <= DEG; j++) begin
        if (POLY[j] && (k - j) >= 0 && (k - j) < a.size()) s ^= a[k-j];
      end
      c.push_back(s);
    end
    return c;
  endfunction

  function automatic bitq_t series_div(input bitq_t r);
    bitq_t q;
    for (int n = 0; n < r.size(); n++) begin
      bit s = r[n];
      for (int j = 1; j <= DEG; j++) begin
        if (POLY[j] && (n - j) >= 0) s ^= q[n-j];
      end
      q.push_back(s);
    end
    return q;
  endfunction

  // long division from the top power down
  function automatic bit has_remainder(input bitq_t r);
    bitq_t w;
    bit nz = 1'b0;
    w = r;
    for (int i = w.size() - 1; i >= DEG; i--) begin
      if (w[i]) begin
        for (int j = 0; j <= DEG; j++) w[i-DEG+j] ^= POLY[j];
      end
    end
    for (int i = 0; i < w.size() && i < DEG; i++) nz |= w[i];
    return nz;
  endfunction

  function automatic bitq_t rand_bits(input int len);
    bitq_t a;
    for (int i = 0; i < len; i++) a.push_back(1'($urandom));
    return a;
  endfunction

  task automatic send_frame(input bit md, input bitq_t bits, input bitq_t expq,
                            input bit exp_rej, input int gap, input bit junk,
                            input bit flip, input string tag);
    int start_n;
    int want;
    start_n = n_out;
    want = expq.size();
    foreach (expq[i]) begin
      exp_q.push_back(expq[i]);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < bits.size(); i++) begin
      @(negedge clk);
      if (i == 1) check(rej_flag == 1'b0, "R7 flag cleared after start", rej_flag, 0);
      in_valid = 1'b1;
      in_bit   = bits[i];
      in_sof   = (i == 0);
      in_eof   = (i == bits.size() - 1);
      mode_div = (flip && i > 0) ? ~md : md;
      @(posedge clk);
      if (gap > 0 && (i % gap) == gap - 1 && i != bits.size() - 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_bit   = 1'b1;
        in_sof   = 1'b1;
        @(posedge clk);
      end
    end
    @(negedge clk);
    if (md) begin
      check(chk_done == 1'b1, "R6 check pulse after end", chk_done, 1);
      check(rej_flag == exp_rej, "R6 reject verdict", rej_flag, exp_rej);
    end else begin
      check(chk_done == 1'b0, "R10 no check pulse in multiply", chk_done, 0);
    end
    in_valid = junk;
    in_sof   = junk;
    in_eof   = junk;
    in_bit   = junk;
    mode_div = junk;
    if (junk) begin
      repeat (DEG) @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
      in_eof   = 1'b0;
    end
    @(negedge clk);
    if (md) check(chk_done == 1'b0, "R6 check pulse lasts one cycle", chk_done, 0);
    repeat (DEG + 3) @(negedge clk);
    check((n_out - start_n) == want, md ? "R5 output count" : "R3 output count",
          n_out - start_n, want);
    check(exp_q.size() == 0, "R4 stream fully consumed", exp_q.size(), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    bitq_t a, r, e;
    rst_n = 1'b0; mode_div = 1'b0; in_valid = 1'b0;
    in_bit = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    check(chk_done == 1'b0, "R1 chk_done in reset", chk_done, 0);
    check(rej_flag == 1'b0, "R1 rej_flag in reset", rej_flag, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(rej_flag == 1'b0, "R1 rej_flag after reset", rej_flag, 0);
    mon_en = 1'b1;

    // R2/R3: plain multiply frame
    a = rand_bits(20);
    send_frame(1'b0, a, polymul(a), 1'b0, 0, 1'b0, 1'b0, "R2 product bit");

    // R4/R9: gaps inside frame, traffic during flush
    a = rand_bits(13);
    send_frame(1'b0, a, polymul(a), 1'b0, 3, 1'b1, 1'b0, "R4 product bit with flush traffic");

    // R3: single-bit frame, impulse gives the polynomial itself
    a = {1'b1};
    send_frame(1'b0, a, polymul(a), 1'b0, 0, 1'b0, 1'b0, "R3 single-bit product");

    // R6: clean code word returns data then zeros
    a = rand_bits(12);
    r = polymul(a);
    e = a;
    for (int i = 0; i < DEG; i++) e.push_back(1'b0);
    send_frame(1'b1, r, e, 1'b0, 4, 1'b0, 1'b0, "R6 recovered data");

    // R6/R5: corrupted word is rejected
    a = rand_bits(12);
    r = polymul(a);
    r[5] = ~r[5];
    send_frame(1'b1, r, series_div(r), has_remainder(r), 0, 1'b0, 1'b0, "R5 quotient bit");

    // R7: verdict held while idle
    repeat (6) @(negedge clk);
    check(rej_flag == 1'b1, "R7 verdict held while idle", rej_flag, 1);

    // R8: mode toggled mid-frame in multiply
    a = rand_bits(9);
    send_frame(1'b0, a, polymul(a), 1'b0, 0, 1'b0, 1'b1, "R8 product bit mode toggled");

    // R8: mode toggled mid-frame in divide, clean word
    a = rand_bits(7);
    r = polymul(a);
    e = a;
    for (int i = 0; i < DEG; i++) e.push_back(1'b0);
    send_frame(1'b1, r, e, 1'b0, 2, 1'b0, 1'b1, "R8 recovered data mode toggled");

    // R6: frames shorter than the divisor degree
    a = {1'b1, 1'b0, 1'b1};
    send_frame(1'b1, a, series_div(a), 1'b1, 0, 1'b0, 1'b0, "R6 short nonzero quotient");
    a = {1'b0, 1'b0, 1'b0};
    send_frame(1'b1, a, series_div(a), 1'b0, 0, 1'b0, 1'b0, "R6 short zero quotient");
    a = {1'b1};
    send_frame(1'b1, a, series_div(a), 1'b1, 0, 1'b0, 1'b0, "R6 single-bit quotient");

    // R5: longer random frame
    r = rand_bits(40);
    send_frame(1'b1, r, series_div(r), has_remainder(r), 5, 1'b0, 1'b0, "R5 long quotient bit");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule